// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block is a single memory-to-memory copy channel. Software programs a source address, a destination address, a unit count and a control word through a small register write port. Setting the enable bit starts a copy. The channel takes private working copies of the addresses and the count. Two cycles later it begins moving data as alternating read and write accesses on a simple request/acknowledge bus. Each access moves one halfword or one word.

Both addresses move after every unit according to their own step code. When the count runs out, the channel either drops its enable or stays armed for a repeat start. A repeat start comes in on a trigger input. The channel can pulse an interrupt on completion. The `CNT_W` parameter sets how many count bits the channel honours: 14 for a reduced channel, 16 for a full one.

Top module: `dmae_channel`

## Requirements
- R1: After reset, `busy`, `mem_req` and `irq` are low and `ctrl_rd` reads zero.
- R2: A control write that sets bit 15 while it is clear and the channel is idle copies the programmed source, destination and count into working registers at that clock edge. `busy` rises after that edge. The first `mem_req` appears after the second following edge and not before.
- R3: Each unit is a read of the source address followed by a write of the read data to the destination address. A halfword write carries the low 16 bits with the upper half zero. `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ack`.
- R4: Destination step code in control bits 6:5: 0 increments, 1 decrements, 2 holds, 3 increments. Source step code in bits 8:7: 0 increments, 1 decrements, 2 holds, and 3 also holds.
- R5: Control bit 10 selects word units (1) or halfword units (0). `mem_word` mirrors this bit. A step is 4 bytes for word units and 2 bytes for halfword units. `mem_addr` has its low two bits (word) or its low bit (halfword) forced to zero.
- R6: Only the low `CNT_W` bits of the count register are kept. A kept value of zero means 2^`CNT_W` units.
- R7: Register writes made while a copy runs do not change that copy. The working registers never write back, so a later start uses exactly the last programmed values.
- R8: When the last write is accepted, `busy` falls. Enable (bit 15) clears if repeat (bit 9) is 0 and stays set if repeat is 1.
- R9: A `trig` pulse while idle with enable and repeat set reloads only the count. If the destination step code is 3, it also reloads the destination. The source and any other destination continue from where the previous copy ended. The first request appears after the second edge following the trigger edge.
- R10: If control bit 14 is set, `irq` is high for exactly one cycle, in the cycle after the last write is accepted. Otherwise `irq` stays low.
- R11: `trig` is ignored when enable is clear or the channel is busy. Control writes are ignored while busy. A control write to an already-enabled channel starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| reg_wdata | input | 32 | Register write data |
| trig | input | 1 | Repeat start request |
| ctrl_rd | output | 16 | Current control register value |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | Access is a write |
| mem_word | output | 1 | Access is a word (else halfword) |
| mem_addr | output | AW | Aligned access address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` on a read |
| busy | output | 1 | Channel is between latching and its last accepted write |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the repeat path, where the destination either continues or reloads depending on its step code. A design that reloaded the wrong registers would restart the source, or would fail to jump the destination back, and both errors show up as misplaced bus addresses.

The count-zero case is exercised at its full reduced size, together with a count whose upper bits must be dropped. A wrong decode would copy no units, or far too many.

Misaligned programmed addresses, source step code 3, and acknowledge stalls expose alignment, stepping and handshake-hold faults. Control writes and triggers landing mid-copy must be ignored; a design that honoured them would abort the copy or start a spurious one.

// File: rtl/dmae_pkg.sv
package dmae_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DLY  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } dmae_state_e;

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    localparam int CB_DSTEP = 5;
    localparam int CB_SSTEP = 7;
    localparam int CB_RPT   = 9;
    localparam int CB_WORD  = 10;
    localparam int CB_IRQ   = 14;
    localparam int CB_EN    = 15;

    localparam logic [1:0] STEP_INC  = 2'd0;
    localparam logic [1:0] STEP_DEC  = 2'd1;
    localparam logic [1:0] STEP_HOLD = 2'd2;
    localparam logic [1:0] STEP_ALT  = 2'd3;

endpackage

// File: rtl/dmae_count_load.sv
module dmae_count_load #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_prog,
    output logic [CNT_W:0]   cnt_eff
);
    // A zero count stands for the largest count the channel can express.
    always_comb begin
        if (cnt_prog == '0) begin
            cnt_eff = {1'b1, {CNT_W{1'b0}}};
        end else begin
            cnt_eff = {1'b0, cnt_prog};
        end
    end
endmodule

// File: rtl/dmae_addr_step.sv
module dmae_addr_step
    import dmae_pkg::*;
#(
    parameter int AW     = 32,
    parameter bit IS_DST = 1'b0
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    mode,
    input  logic          word,
    output logic [AW-1:0] addr_nx
);
    logic [AW-1:0] delta;
    logic [AW-1:0] alt_nx;

    assign delta = word ? AW'(4) : AW'(2);

    // Code 3 differs between the two address paths.
    generate
        if (IS_DST) begin : g_dst_alt
            assign alt_nx = addr + delta;
        end else begin : g_src_alt
            assign alt_nx = addr;
        end
    endgenerate

    always_comb begin
        case (mode)
            STEP_INC:  addr_nx = addr + delta;
            STEP_DEC:  addr_nx = addr - delta;
            STEP_HOLD: addr_nx = addr;
            default:   addr_nx = alt_nx;
        endcase
    end
endmodule

// File: rtl/dmae_channel.sv
module dmae_channel
    import dmae_pkg::*;
#(
    parameter int AW        = 32,
    parameter int CNT_W     = 16,
    parameter int START_DLY = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    input  logic          trig,
    output logic [15:0]   ctrl_rd,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_word,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          busy,
    output logic          irq
);
    localparam int CW = CNT_W + 1;
    localparam int DW = (START_DLY > 1) ? $clog2(START_DLY) : 1;

    typedef struct packed {
        dmae_state_e    st;
        logic [AW-1:0]  src_p;
        logic [AW-1:0]  dst_p;
        logic [CNT_W-1:0] cnt_p;
        logic [15:0]    ctrl;
        logic [AW-1:0]  src_w;
        logic [AW-1:0]  dst_w;
        logic [CW-1:0]  cnt_w;
        logic [31:0]    data;
        logic [DW-1:0]  dly;
        logic           irq;
    } regs_t;

    regs_t r_q, r_d;

    logic [CW-1:0] cnt_eff;
    logic [AW-1:0] src_nx, dst_nx, acc_addr;
    logic          word_mode;
    logic          idle, full_start, rpt_start;

    assign word_mode = r_q.ctrl[CB_WORD];

    dmae_count_load #(.CNT_W(CNT_W)) u_cnt (
        .cnt_prog (r_q.cnt_p),
        .cnt_eff  (cnt_eff)
    );

    dmae_addr_step #(.AW(AW), .IS_DST(1'b0)) u_src_step (
        .addr    (r_q.src_w),
        .mode    (r_q.ctrl[CB_SSTEP +: 2]),
        .word    (word_mode),
        .addr_nx (src_nx)
    );

    dmae_addr_step #(.AW(AW), .IS_DST(1'b1)) u_dst_step (
        .addr    (r_q.dst_w),
        .mode    (r_q.ctrl[CB_DSTEP +: 2]),
        .word    (word_mode),
        .addr_nx (dst_nx)
    );

    assign idle       = (r_q.st == ST_IDLE);
    assign full_start = idle && reg_we && (reg_sel == SEL_CTRL) &&
                        reg_wdata[CB_EN] && !r_q.ctrl[CB_EN];
    assign rpt_start  = idle && trig && r_q.ctrl[CB_EN] && r_q.ctrl[CB_RPT];

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;

        if (reg_we) begin
            case (reg_sel)
                SEL_SRC: r_d.src_p = reg_wdata[AW-1:0];
                SEL_DST: r_d.dst_p = reg_wdata[AW-1:0];
                SEL_CNT: r_d.cnt_p = reg_wdata[CNT_W-1:0];
                default: begin
                    if (idle && !rpt_start) begin
                        r_d.ctrl = reg_wdata[15:0];
                    end
                end
            endcase
        end

        if (full_start) begin
            r_d.src_w = r_q.src_p;
            r_d.dst_w = r_q.dst_p;
            r_d.cnt_w = cnt_eff;
            r_d.dly   = '0;
            r_d.st    = ST_DLY;
        end else if (rpt_start) begin
            r_d.cnt_w = cnt_eff;
            if (r_q.ctrl[CB_DSTEP +: 2] == STEP_ALT) begin
                r_d.dst_w = r_q.dst_p;
            end
            r_d.dly = '0;
            r_d.st  = ST_DLY;
        end

        case (r_q.st)
            ST_DLY: begin
                if (r_q.dly == DW'(START_DLY - 1)) begin
                    r_d.st = ST_RD;
                end else begin
                    r_d.dly = r_q.dly + 1'b1;
                end
            end
            ST_RD: begin
                if (mem_ack) begin
                    r_d.data = word_mode ? mem_rdata : {16'h0000, mem_rdata[15:0]};
                    r_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_ack) begin
                    r_d.src_w = src_nx;
                    r_d.dst_w = dst_nx;
                    r_d.cnt_w = r_q.cnt_w - 1'b1;
                    if (r_q.cnt_w == CW'(1)) begin
                        r_d.st = ST_IDLE;
                        r_d.irq = r_q.ctrl[CB_IRQ];
                        if (!r_q.ctrl[CB_RPT]) begin
                            r_d.ctrl[CB_EN] = 1'b0;
                        end
                    end else begin
                        r_d.st = ST_RD;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign acc_addr  = (r_q.st == ST_WR) ? r_q.dst_w : r_q.src_w;
    assign mem_addr  = word_mode ? {acc_addr[AW-1:2], 2'b00} : {acc_addr[AW-1:1], 1'b0};
    assign mem_req   = (r_q.st == ST_RD) || (r_q.st == ST_WR);
    assign mem_we    = (r_q.st == ST_WR);
    assign mem_word  = word_mode;
    assign mem_wdata = r_q.data;
    assign busy      = !idle;
    assign irq       = r_q.irq;
    assign ctrl_rd   = r_q.ctrl;

endmodule

// File: rtl/dmae_channel_chk.sv
module dmae_channel_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [1:0]    reg_sel,
    input logic [15:0]   ctrl_rd,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_word,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          busy,
    input logic          irq
);
    // R3: a pending request holds still until accepted
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R3: an accepted read is followed by a write
    a_r3_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack |=> mem_req && mem_we);

    // R2: bus activity only while busy
    a_r2_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R5: addresses are aligned to the unit size
    a_r5_align: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[0] == 1'b0) && (!mem_word || mem_addr[1] == 1'b0));

    // R10: interrupt is a single-cycle pulse
    a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R10: interrupt only right after completion
    a_r10_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy && $past(busy));

    // R8: enable drops by itself only when repeat is off
    a_r8_en_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_rd[15]) && !$past(reg_we && reg_sel == 2'd3) |-> !ctrl_rd[9]);

endmodule

bind dmae_channel dmae_channel_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_sel  (reg_sel),
    .ctrl_rd  (ctrl_rd),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_word (mem_word),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .busy     (busy),
    .irq      (irq)
);

// File: tb/test_dmae_channel.sv
module test_dmae_channel;
    localparam int AW    = 32;
    localparam int CNT_W = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [31:0]   reg_wdata = 32'd0;
    logic          trig = 1'b0;
    logic [15:0]   ctrl_rd;
    logic          mem_req, mem_we, mem_word;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_ack = 1'b0;
    logic [31:0]   mem_rdata = 32'd0;
    logic          busy, irq;

    dmae_channel #(.AW(AW), .CNT_W(CNT_W), .START_DLY(2)) i_dmae_channel (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .trig(trig), .ctrl_rd(ctrl_rd),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .busy(busy), .irq(irq)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        logic        word;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_e;
    int   n_chk = 0;
    int   n_err = 0;
    int   irq_seen = 0;
    int   stall_ctr = 0;
    bit   stall_en = 1'b0;
    logic [31:0] s_end, d_end;

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return a ^ 32'h5A5A_C3C3 ^ {a[15:0], a[31:16]};
    endfunction

    function automatic logic [31:0] align(input logic [31:0] a, input bit word);
        return word ? {a[31:2], 2'b00} : {a[31:1], 1'b0};
    endfunction

    function automatic logic [31:0] step(input logic [31:0] a, input logic [1:0] m,
                                         input bit word, input bit is_dst);
        logic [31:0] d;
        d = word ? 32'd4 : 32'd2;
        case (m)
            2'd0: return a + d;
            2'd1: return a - d;
            2'd2: return a;
            default: return is_dst ? a + d : a;
        endcase
    endfunction

    function automatic logic [15:0] ctl(input bit en, input bit ie, input bit word,
                                        input bit rpt, input logic [1:0] sm,
                                        input logic [1:0] dm);
        return {en, ie, 3'b000, word, rpt, sm, dm, 5'b00000};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: acknowledges requests and compares them against the scoreboard
    always @(negedge clk) begin
        mem_ack = 1'b0;
        if (rst_n && mem_req) begin
            stall_ctr++;
            if (!stall_en || (stall_ctr % 3) != 0) begin
                mem_ack   = 1'b1;
                mem_rdata = mem_val(mem_addr);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected access", mem_addr, 32'd0);
                end else begin
                    mon_e = exp_q.pop_front();
                    check(mem_we == mon_e.we && mem_addr == mon_e.addr &&
                          mem_word == mon_e.word && (!mon_e.we || mem_wdata == mon_e.data),
                          mon_e.req, mon_e.we ? "write access" : "read access",
                          mon_e.we ? mem_wdata : mem_addr,
                          mon_e.we ? mon_e.data : mon_e.addr);
                end
            end
        end
        if (irq) irq_seen++;
    end

    // Driver: pushes the expected access sequence for one copy
    task automatic push_run(input logic [31:0] src, input logic [31:0] dst, input int n,
                            input logic [1:0] dm, input logic [1:0] sm, input bit word,
                            input string req, output logic [31:0] se, output logic [31:0] de);
        logic [31:0] v;
        exp_t e;
        for (int i = 0; i < n; i++) begin
            v = mem_val(align(src, word));
            e.we = 1'b0; e.addr = align(src, word); e.data = 32'd0; e.word = word; e.req = req;
            exp_q.push_back(e);
            e.we = 1'b1; e.addr = align(dst, word);
            e.data = word ? v : {16'h0000, v[15:0]};
            exp_q.push_back(e);
            src = step(src, sm, word, 1'b0);
            dst = step(dst, dm, word, 1'b1);
        end
        se = src;
        de = dst;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // Start through a control write or a trigger, then check the start delay
    task automatic kick(input bit use_trig, input logic [15:0] c, input string req);
        if (use_trig) begin
            @(negedge clk);
            trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
        end else begin
            wr(2'd3, {16'h0000, c});
        end
        check(busy && !mem_req, req, "busy set, no request yet", {busy, mem_req}, 2'b10);
        @(negedge clk);
        check(!mem_req, req, "no request one edge later", mem_req, 1'b0);
        @(negedge clk);
        check(mem_req, req, "request two edges later", mem_req, 1'b1);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (busy || exp_q.size() != 0);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 190000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int irq0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(!busy && !mem_req && !irq && ctrl_rd == 16'h0, "R1", "reset state",
              {busy, mem_req, irq, ctrl_rd}, 32'd0);

        // R2 R3 R10 R8: halfword increment copy with interrupt
        wr(2'd0, 32'h0000_1000); wr(2'd1, 32'h0000_2000); wr(2'd2, 32'd4);
        push_run(32'h1000, 32'h2000, 4, 2'd0, 2'd0, 1'b0, "R3", s_end, d_end);
        irq0 = irq_seen;
        kick(1'b0, ctl(1, 1, 0, 0, 2'd0, 2'd0), "R2");
        wait_done();
        check(irq_seen == irq0 + 1, "R10", "irq pulse count", irq_seen - irq0, 1);
        check(ctrl_rd[15] == 1'b0, "R8", "enable cleared without repeat", ctrl_rd[15], 1'b0);

        // R4 R5: word units, destination decrement, source hold, misaligned, stalls
        stall_en = 1'b1;
        wr(2'd0, 32'h0000_3003); wr(2'd1, 32'h0000_4006); wr(2'd2, 32'd5);
        push_run(32'h3003, 32'h4006, 5, 2'd1, 2'd2, 1'b1, "R4", s_end, d_end);
        irq0 = irq_seen;
        kick(1'b0, ctl(1, 0, 1, 0, 2'd2, 2'd1), "R2");
        wait_done();
        check(irq_seen == irq0, "R10", "no irq when disabled", irq_seen - irq0, 0);
        check(mem_word == 1'b1, "R5", "word flag mirrors bit 10", mem_word, 1'b1);

        // R4 R5: halfword, source decrement misaligned, destination hold
        wr(2'd0, 32'h0000_5001); wr(2'd1, 32'h0000_6000); wr(2'd2, 32'd3);
        push_run(32'h5001, 32'h6000, 3, 2'd2, 2'd1, 1'b0, "R5", s_end, d_end);
        kick(1'b0, ctl(1, 0, 0, 0, 2'd1, 2'd2), "R2");
        wait_done();

        // R4: code 3 on both paths, word units
        wr(2'd0, 32'h0000_5100); wr(2'd1, 32'h0000_6100); wr(2'd2, 32'd3);
        push_run(32'h5100, 32'h6100, 3, 2'd3, 2'd3, 1'b1, "R4", s_end, d_end);
        kick(1'b0, ctl(1, 0, 1, 0, 2'd3, 2'd3), "R2");
        wait_done();
        stall_en = 1'b0;

        // R7: register writes during a copy, then restarts
        wr(2'd0, 32'h0000_7000); wr(2'd1, 32'h0000_7800); wr(2'd2, 32'd6);
        push_run(32'h7000, 32'h7800, 6, 2'd0, 2'd0, 1'b0, "R7", s_end, d_end);
        kick(1'b0, ctl(1, 0, 0, 0, 2'd0, 2'd0), "R2");
        wr(2'd0, 32'h0000_9000); wr(2'd1, 32'h0000_9800); wr(2'd2, 32'd2);
        wait_done();
        push_run(32'h9000, 32'h9800, 2, 2'd0, 2'd0, 1'b0, "R7", s_end, d_end);
        kick(1'b0, ctl(1, 0, 0, 0, 2'd0, 2'd0), "R7");
        wait_done();
        push_run(32'h9000, 32'h9800, 2, 2'd0, 2'd0, 1'b0, "R7", s_end, d_end);
        kick(1'b0, ctl(1, 0, 0, 0, 2'd0, 2'd0), "R7");
        wait_done();

        // R9 R11 R8: repeat operation
        wr(2'd0, 32'h0000_A000); wr(2'd1, 32'h0000_B000); wr(2'd2, 32'd3);
        push_run(32'hA000, 32'hB000, 3, 2'd0, 2'd0, 1'b0, "R9", s_end, d_end);
        irq0 = irq_seen;
        kick(1'b0, ctl(1, 1, 0, 1, 2'd0, 2'd0), "R2");
        wr(2'd3, 32'h0000_0000);
        @(negedge clk); trig = 1'b1; @(negedge clk); trig = 1'b0;
        wait_done();
        check(ctrl_rd[15] == 1'b1, "R8", "enable kept with repeat", ctrl_rd[15], 1'b1);
        check(ctrl_rd == ctl(1, 1, 0, 1, 2'd0, 2'd0), "R11", "control write while busy ignored",
              ctrl_rd, ctl(1, 1, 0, 1, 2'd0, 2'd0));
        check(irq_seen == irq0 + 1, "R10", "irq on repeat copy", irq_seen - irq0, 1);

        wr(2'd2, 32'd2); wr(2'd1, 32'h0000_C000);
        push_run(s_end, d_end, 2, 2'd0, 2'd0, 1'b0, "R9", s_end, d_end);
        kick(1'b1, 16'h0, "R9");
        wait_done();

        wr(2'd3, {16'h0000, ctl(1, 0, 0, 1, 2'd0, 2'd3)});
        repeat (4) @(negedge clk);
        check(!busy, "R11", "control write on enabled channel starts nothing", busy, 1'b0);
        push_run(s_end, 32'h0000_C000, 2, 2'd3, 2'd0, 1'b0, "R9", s_end, d_end);
        kick(1'b1, 16'h0, "R9");
        wait_done();
        push_run(s_end, 32'h0000_C000, 2, 2'd3, 2'd0, 1'b0, "R9", s_end, d_end);
        kick(1'b1, 16'h0, "R9");
        wait_done();

        wr(2'd3, 32'h0000_0000);
        @(negedge clk); trig = 1'b1; @(negedge clk); trig = 1'b0;
        repeat (5) @(negedge clk);
        check(!busy && exp_q.size() == 0, "R11", "trigger ignored when disabled", busy, 1'b0);

        // R6: upper count bits dropped
        wr(2'd0, 32'h0000_D000); wr(2'd1, 32'h0000_E000); wr(2'd2, 32'h0000_4003);
        push_run(32'hD000, 32'hE000, 3, 2'd2, 2'd2, 1'b1, "R6", s_end, d_end);
        kick(1'b0, ctl(1, 0, 1, 0, 2'd2, 2'd2), "R6");
        wait_done();

        // R6: zero count means the maximum
        wr(2'd0, 32'h0001_0000); wr(2'd1, 32'h0002_0000); wr(2'd2, 32'h0000_0000);
        push_run(32'h0001_0000, 32'h0002_0000, 1 << CNT_W, 2'd0, 2'd0, 1'b0, "R6", s_end, d_end);
        irq0 = irq_seen;
        kick(1'b0, ctl(1, 1, 0, 0, 2'd0, 2'd0), "R6");
        wait_done();
        check(irq_seen == irq0 + 1 && exp_q.size() == 0, "R6", "maximum count completes",
              irq_seen - irq0, 1);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3", "all expected accesses seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule